// File: doc/BRIEF.md
# PCI Interrupt Pin Swizzle Router

This block turns interrupt assert and deassert events raised by PCI functions into levels on a vector of system interrupt lines. Each event carries the function's interrupt pin value (1 for INTA up to 4 for INTD) and its device/function index. The device number and the pin select one of four routing slots. This rotation spreads the pins of devices in neighbouring slots across the four shared board wires.

The slot picks one of four routing bytes. The bridge writes these bytes through configuration writes at byte offsets 0x60 to 0x63. A routing byte either names a target line or disables its slot. Several sources can share one line. Each line keeps a count of the sources that currently assert it, and the line stays high while that count is non-zero.

Top module: `pci_irq_swizzle`

## Requirements
- R1: After reset, `irq_o` is all zero and every routing byte is 0x80, which is disabled. Requests made before any configuration write change no line.
- R2: A request's slot is ((pin - 1) + (device - 1)) mod 4, where device is `req_devfn_i[7:3]`. Device 0 with pin 1 gives slot 3.
- R3: A configuration write to offset 0x60 + s stores the routing byte of slot s. Bits 3:0 of that byte name the target line, and bits 6:4 are ignored. A request in the same cycle as a write uses the routing that was in place before the write.
- R4: When bit 7 of a slot's routing byte is set, requests that map to that slot are ignored.
- R5: Configuration writes to offsets outside 0x60 to 0x63 change no routing byte.
- R6: Requests with a pin value of 0 or greater than 4 are ignored.
- R7: A line shared by several asserting sources stays high until every one of them has deasserted.
- R8: A deassert request goes through the same slot calculation as an assert request, so it lowers the line that the matching assert raised.
- R9: A deassert request on a line whose count is zero has no effect. A single assert that follows it raises the line.
- R10: Each line counter saturates at 2^CNT_W - 1 and never wraps. With the default width, 16 asserts followed by 15 deasserts leave the line low.
- R11: A request sampled on one rising clock edge is visible on `irq_o` right after that edge. At most one line changes per cycle, and no line changes in a cycle without a valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration byte write strobe for the bridge function |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| req_valid_i | input | 1 | Interrupt request strobe |
| req_assert_i | input | 1 | 1 = assert, 0 = deassert |
| req_pin_i | input | 8 | Interrupt pin register value of the requesting function |
| req_devfn_i | input | 8 | Device/function index of the requesting function |
| irq_o | output | N_LINES | Interrupt line levels |

## Verification
The hardest state to reach is a counter sitting at its saturation limit. Only a long run of asserts on one line, with no deasserts in between, gets it there, and random traffic almost never produces such a run. A directed sequence therefore issues sixteen asserts through one slot and then counts the line back down. Shared lines and deasserts on idle lines come from directed pairs of devices whose swizzles land on the same slot. After those, random traffic mixes routing rewrites, including rewrites in the same cycle as a request, with requests carrying out-of-range pins.

// File: rtl/pci_irq_swz_pkg.sv
package pci_irq_swz_pkg;
  localparam int unsigned SLOTS = 4;
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam logic [7:0] ROUTE_RESET = 8'h80;
  localparam int unsigned DIS_BIT = 7;

  typedef logic [7:0] route_t;
  typedef logic [SLOT_W-1:0] slot_t;

  // (pin-1)+(dev-1) folded onto the slot count
  function automatic slot_t calc_slot(input logic [7:0] pin, input logic [7:0] devfn);
    logic [7:0] sum;
    sum = pin + {3'b000, devfn[7:3]} - 8'd2;
    return sum[SLOT_W-1:0];
  endfunction

  function automatic logic pin_ok(input logic [7:0] pin);
    return (pin >= 8'd1) && (pin <= 8'd4);
  endfunction
endpackage

// File: rtl/swz_route_regs.sv
module swz_route_regs
  import pci_irq_swz_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h60
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [7:0]              addr_i,
  input  logic [7:0]              wdata_i,
  output logic [SLOTS-1:0][7:0]   route_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [7:0] OFF = BASE + 8'(s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          route_o[s] <= ROUTE_RESET;
      else if (we_i && (addr_i == OFF))     route_o[s] <= wdata_i;
    end
  end
endmodule

// File: rtl/swz_lookup.sv
module swz_lookup
  import pci_irq_swz_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  localparam int unsigned LINE_W = $clog2(N_LINES)
) (
  input  logic                  valid_i,
  input  logic [7:0]            pin_i,
  input  logic [7:0]            devfn_i,
  input  logic [SLOTS-1:0][7:0] route_i,
  output logic                  hit_o,
  output logic [LINE_W-1:0]     line_o
);
  slot_t  slot;
  route_t rb;

  always_comb begin
    slot   = calc_slot(pin_i, devfn_i);
    rb     = route_i[slot];
    line_o = rb[LINE_W-1:0];
    hit_o  = valid_i && pin_ok(pin_i) && !rb[DIS_BIT] &&
             (32'(line_o) < N_LINES);
  end
endmodule

// File: rtl/swz_line_ctr.sv
module swz_line_ctr #(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned CNT_W = 4,
  localparam int unsigned LINE_W = $clog2(N_LINES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       hit_i,
  input  logic                       up_i,
  input  logic [LINE_W-1:0]          line_i,
  output logic [N_LINES*CNT_W-1:0]   cnt_o,
  output logic [N_LINES-1:0]         lvl_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic [CNT_W-1:0] cnt_q;
    logic sel;
    assign sel = hit_i && (32'(line_i) == l);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (sel) begin
        if (up_i && cnt_q != CMAX)       cnt_q <= cnt_q + 1'b1;
        else if (!up_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
    end

    assign cnt_o[l*CNT_W +: CNT_W] = cnt_q;
    assign lvl_o[l] = |cnt_q;
  end
endmodule

// File: rtl/pci_irq_swizzle.sv
module pci_irq_swizzle
  import pci_irq_swz_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned CNT_W = 4,
  parameter logic [7:0]  ROUTE_BASE = 8'h60
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [7:0]         cfg_addr_i,
  input  logic [7:0]         cfg_wdata_i,
  input  logic               req_valid_i,
  input  logic               req_assert_i,
  input  logic [7:0]         req_pin_i,
  input  logic [7:0]         req_devfn_i,
  output logic [N_LINES-1:0] irq_o
);
  localparam int unsigned LINE_W = $clog2(N_LINES);

  logic [SLOTS-1:0][7:0]     route;
  logic                      hit;
  logic [LINE_W-1:0]         line;
  logic [N_LINES*CNT_W-1:0]  cnt_flat;

  swz_route_regs #(.BASE(ROUTE_BASE)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .route_o (route)
  );

  swz_lookup #(.N_LINES(N_LINES)) u_look (
    .valid_i (req_valid_i),
    .pin_i   (req_pin_i),
    .devfn_i (req_devfn_i),
    .route_i (route),
    .hit_o   (hit),
    .line_o  (line)
  );

  swz_line_ctr #(.N_LINES(N_LINES), .CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .up_i   (req_assert_i),
    .line_i (line),
    .cnt_o  (cnt_flat),
    .lvl_o  (irq_o)
  );
endmodule

// File: rtl/pci_irq_swizzle_chk.sv
module pci_irq_swizzle_chk #(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned CNT_W = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_valid_i,
  input logic                      req_assert_i,
  input logic [7:0]                req_pin_i,
  input logic [N_LINES-1:0]        irq_o,
  input logic [N_LINES*CNT_W-1:0]  cnt_flat
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_one_change_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o ^ $past(irq_o)) <= 1);

  p_idle_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_valid_i) |-> $stable(irq_o));

  p_bad_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && (req_pin_i == 8'd0 || req_pin_i > 8'd4)) |-> $stable(irq_o));

  p_rise_on_assert_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~$past(irq_o)) != '0) |-> $past(req_valid_i && req_assert_i));

  p_fall_on_deassert_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~irq_o & $past(irq_o)) != '0) |-> $past(req_valid_i && !req_assert_i));

  for (genvar l = 0; l < N_LINES; l++) begin : g_sat
    p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cnt_flat[l*CNT_W +: CNT_W]) == CMAX && $past(req_assert_i))
      |-> cnt_flat[l*CNT_W +: CNT_W] == CMAX);
  end
endmodule

bind pci_irq_swizzle pci_irq_swizzle_chk #(.N_LINES(N_LINES), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_assert_i (req_assert_i),
  .req_pin_i    (req_pin_i),
  .irq_o        (irq_o),
  .cnt_flat     (cnt_flat)
);

// File: tb/sim_pci_irq_swizzle.sv
module sim_pci_irq_swizzle;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int CMAXV = 15;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [7:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic req_valid_i = 1'b0;
  logic req_assert_i = 1'b0;
  logic [7:0] req_pin_i = '0;
  logic [7:0] req_devfn_i = '0;
  logic [NL-1:0] irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] m_route [4];
  int m_cnt [NL];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pci_irq_swizzle u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .req_valid_i(req_valid_i), .req_assert_i(req_assert_i),
    .req_pin_i(req_pin_i), .req_devfn_i(req_devfn_i), .irq_o(irq_o)
  );

  function automatic logic [NL-1:0] exp_irq();
    logic [NL-1:0] v;
    for (int i = 0; i < NL; i++) v[i] = (m_cnt[i] != 0);
    return v;
  endfunction

  function automatic int slot_of(input int pin, input int devfn);
    return ((pin - 1) + (devfn >> 3) - 1) & 3;
  endfunction

  task automatic model_req(input bit a, input int pin, input int devfn);
    int s; int ln;
    if (pin < 1 || pin > 4) return;
    s = slot_of(pin, devfn);
    if (m_route[s][7]) return;
    ln = m_route[s][3:0];
    if (a) begin if (m_cnt[ln] < CMAXV) m_cnt[ln]++; end
    else   begin if (m_cnt[ln] > 0) m_cnt[ln]--; end
  endtask

  // one cycle: optional cfg write and optional request, starting at negedge
  task automatic cyc(input bit we, input int addr, input int wd,
                     input bit v, input bit a, input int pin, input int devfn);
    cfg_we_i = we; cfg_addr_i = 8'(addr); cfg_wdata_i = 8'(wd);
    req_valid_i = v; req_assert_i = a; req_pin_i = 8'(pin); req_devfn_i = 8'(devfn);
    if (v) model_req(a, pin, devfn);
    if (we && addr >= 8'h60 && addr <= 8'h63) m_route[addr - 8'h60] = 8'(wd);
    @(negedge clk_i);
    cfg_we_i = 0; req_valid_i = 0;
  endtask

  task automatic wr(input int addr, input int wd); cyc(1, addr, wd, 0, 0, 0, 0); endtask
  task automatic rq(input bit a, input int pin, input int devfn); cyc(0, 0, 0, 1, a, pin, devfn); endtask

  task automatic check(input string tag);
    logic [NL-1:0] e;
    e = exp_irq();
    n_chk++;
    if (irq_o !== e) begin
      n_bad++;
      $display("FAIL %s: irq_o=%h expected %h", tag, irq_o, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    for (int i = 0; i < 4; i++) m_route[i] = 8'h80;
    for (int i = 0; i < NL; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 reset");
    // R1: routes disabled after reset
    for (int d = 0; d < 4; d++) rq(1, 1, d << 3);
    check("R1 default routing disabled");

    // R3: program routes; bits 6:4 ignored on slot 2
    wr(8'h60, 8'h05); wr(8'h61, 8'h0A); wr(8'h62, 8'h7B); wr(8'h63, 8'h03);
    // R5: out-of-window writes
    wr(8'h64, 8'h01); wr(8'h5F, 8'h02); wr(8'hE0, 8'h0C);
    rq(1, 1, 1 << 3);  check("R5 slot0 keeps line 5 / R2 dev1 pin1");
    rq(0, 1, 1 << 3);  check("R8 deassert same line");
    rq(1, 1, 0);       check("R2 dev0 pin1 -> slot3");
    rq(0, 1, 0);       check("R8 dev0 deassert");
    rq(1, 2, 2 << 3);  check("R3 bits 6:4 ignored, slot2 -> line 11");
    rq(1, 4, 3 << 3);  check("R2 dev3 pin4 -> slot1");
    rq(0, 2, 2 << 3);  rq(0, 4, 3 << 3); check("R8 both low");

    // R7: shared line via slot0 from two devices
    rq(1, 1, 1 << 3); rq(1, 2, 4 << 3); check("R7 two sources high");
    rq(0, 1, 1 << 3); check("R7 one source left, still high");
    rq(0, 2, 4 << 3); check("R7 all released");

    // R9: deassert at zero
    rq(0, 1, 1 << 3); check("R9 deassert at zero stays low");
    rq(1, 1, 1 << 3); check("R9 single assert raises");
    rq(0, 1, 1 << 3); check("R9 back low");

    // R4: disabled slot
    wr(8'h61, 8'h8A);
    rq(1, 1, 2 << 3); check("R4 disabled slot ignored");
    wr(8'h61, 8'h0A);

    // R6: bad pin values
    rq(1, 0, 1 << 3); rq(1, 5, 1 << 3); rq(1, 7, 2 << 3); rq(1, 255, 0);
    check("R6 bad pins ignored");

    // R3/R11: write and request in same cycle use old routing
    cyc(1, 8'h60, 8'h0E, 1, 1, 1, 1 << 3);
    check("R3 same-cycle write uses old route");
    rq(0, 1, 1 << 3); check("R11 deassert on new route, old line stays");

    // R10: saturation
    wr(8'h63, 8'h09);
    repeat (16) rq(1, 1, 0);
    check("R10 saturated high");
    repeat (14) rq(0, 1, 0);
    check("R10 one count left");
    rq(0, 1, 0);
    check("R10 low after 15 deasserts");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) wr($urandom_range(8'h5E, 8'h65), $urandom_range(0, 255));
      else if (k == 1)
        cyc(1, $urandom_range(8'h60, 8'h63), $urandom_range(0, 255) & 8'h8F,
            1, $urandom_range(0, 1), $urandom_range(0, 5), $urandom_range(0, 255));
      else rq($urandom_range(0, 9) < 6, $urandom_range(0, 5), $urandom_range(0, 255));
      check("R2 R3 R7 R11 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule